// File: doc/BRIEF.md
# Cache Tag and Lookup Controller

This block keeps the tag and valid state of a small cache and decides, for every memory word address it is given, whether the block holding that word is present. It also decides which line the block occupies. The address is cut into three fields: a word offset inside the block, a set index, and a tag. The tags of every way in the selected set are compared in parallel. The answer is hit or miss, together with a way number. On a miss the block is installed at once. The answer also says whether a valid line had to be given up to make room. Data storage and the path to main memory belong to the surrounding logic. This block supplies only the placement decision.

The number of ways per set is a compile-time parameter. With one way the cache is direct-mapped, so a memory block can only go to line (block number mod lines). With as many ways as lines the set field vanishes and the cache is fully associative. Any value in between gives an N-way set-associative cache, in which the set is the block number modulo the number of sets. The replacement policy is chosen at run time from four options: pseudo-random, first-in-first-out, least recently used and most recently used. Three saturating counters record hits, misses and replacements. A synchronous clear input empties the cache.

Requests and responses are valid/ready streams. A request is taken in a cycle where both `req_valid` and `req_ready` are high. Its response is presented one cycle later and stays unchanged until `rsp_ready` is seen high. While a response waits, no new request is taken. The policy and clear pins are plain level inputs.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The word offset is address bits [WORD_BITS-1:0]. The set index is the next log2(LINES/WAYS) bits above it, and the tag is every bit above that. `rsp_set` reports the set index of the request; it reads 0 when there is a single set.
- R2: When a valid way of the selected set holds the request's tag, the response has `rsp_hit`=1, `rsp_evict`=0, and `rsp_way` equal to that way. Tags and valid bits are left unchanged.
- R3: On a miss where the selected set still has an invalid way, the lowest-numbered invalid way is filled with the new tag and marked valid. The response has `rsp_hit`=0, `rsp_evict`=0, and `rsp_way` equal to that way.
- R4: On a miss where every way of the set is valid, the way named by the policy is overwritten, and the response has `rsp_hit`=0, `rsp_evict`=1 and `rsp_way` equal to that way. The policy codes are 0 = pseudo-random, 1 = FIFO, 2 = LRU and 3 = MRU. The pseudo-random choice may name any way of the set.
- R5: FIFO evicts the way whose last fill is the oldest. Hits do not change the FIFO order.
- R6: LRU evicts the way whose most recent hit or fill is the oldest. MRU evicts the way whose most recent hit or fill is the newest.
- R7: With WAYS=1 each memory block has exactly one possible line. With WAYS=LINES there is no set field, and any block may be placed in any line.
- R8: A request is accepted when `req_valid` and `req_ready` are both high, and its response is valid in the following cycle. `req_ready` is low whenever a response is valid but `rsp_ready` is low, and whenever `clr` is high. A response that is not taken keeps all its fields unchanged.
- R9: Every accepted request adds one to exactly one of the hit and miss counters. Every eviction adds one to the replacement counter. Each counter stops at 2^CNT_W-1.
- R10: A cycle with `clr` high invalidates every line and zeroes all three counters. Reset does the same and also leaves no response pending.
- R11: A 4x8 word array stored column-major at addresses 1000 to 1031 is read along its first two rows, A(0,0)..A(0,7) then A(1,0)..A(1,7). This runs through a direct-mapped cache of 8 lines with 2 words per block. The result is 16 misses, 0 hits and 12 replacements, and the misses land in exactly 4 distinct lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous invalidate-all and counter clear |
| policy | input | 2 | Replacement policy code (R4) |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Memory word address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Block was present |
| rsp_evict | output | 1 | A valid block was displaced |
| rsp_way | output | WAY_IW | Way hit or filled |
| rsp_set | output | SET_IW | Set index of the request |
| hit_count | output | CNT_W | Saturating hit count |
| miss_count | output | CNT_W | Saturating miss count |
| repl_count | output | CNT_W | Saturating replacement count |

## Verification
The hardest condition to reach from the ports is a full set whose victim differs between policies. Getting there needs fills and later hits interleaved on the same set, so that the fill order and the use order have drifted apart. The stimulus draws tags from a pool of eight per set over four ways. This keeps sets full and hits frequent, while random pauses on `rsp_ready` hold responses and block requests. Separate directed runs on a fully associative instance and a direct-mapped instance show the same block sequence leading LRU, MRU and FIFO to three different victims, and reproduce the column-major array case.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

  typedef enum logic [1:0] {
    POL_RANDOM = 2'd0,
    POL_FIFO   = 2'd1,
    POL_LRU    = 2'd2,
    POL_MRU    = 2'd3
  } repl_pol_e;

  localparam logic [15:0] LFSR_TAPS = 16'hB400;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/ctc_addr_split.sv
module ctc_addr_split #(
  parameter int ADDR_W    = 16,
  parameter int WORD_BITS = 4,
  parameter int SET_BITS  = 5,
  parameter int SET_IW    = 5,
  parameter int TAG_W     = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SET_IW-1:0] set_idx,
  output logic [TAG_W-1:0]  tag
);

  // offset inside the block is not needed for placement
  logic unused_offset;
  assign unused_offset = ^addr[WORD_BITS-1:0];

  assign tag = addr[ADDR_W-1 -: TAG_W];

  generate
    if (SET_BITS == 0) begin : g_single_set
      assign set_idx = '0;
    end else begin : g_set_field
      assign set_idx = addr[WORD_BITS +: SET_BITS];
    end
  endgenerate

endmodule

// File: rtl/ctc_way_array.sv
module ctc_way_array #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 7,
  parameter int SET_IW = 5,
  parameter int WAY_IW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [SET_IW-1:0] set_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              wr_en,
  input  logic [WAY_IW-1:0] wr_way,
  output logic [WAYS-1:0]   hit_vec,
  output logic [WAYS-1:0]   valid_vec
);

  localparam int DEPTH = 1 << SET_IW;

  logic [TAG_W-1:0] tag_q [DEPTH][WAYS];
  logic [WAYS-1:0]  vld_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < DEPTH; d++) vld_q[d] <= '0;
    end else if (clr) begin
      for (int d = 0; d < DEPTH; d++) vld_q[d] <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < WAYS; w++)
        if (wr_way == WAY_IW'(w)) vld_q[set_idx][w] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) begin
      for (int w = 0; w < WAYS; w++)
        if (wr_way == WAY_IW'(w)) tag_q[set_idx][w] <= lk_tag;
    end
  end

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign valid_vec[w] = vld_q[set_idx][w];
      assign hit_vec[w]   = vld_q[set_idx][w] && (tag_q[set_idx][w] == lk_tag);
    end
  endgenerate

endmodule

// File: rtl/ctc_repl_state.sv
module ctc_repl_state
  import cache_tag_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int WAY_IW = 2,
  parameter int SET_IW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  repl_pol_e         policy,
  input  logic [SET_IW-1:0] set_idx,
  input  logic              touch_en,
  input  logic              touch_fill,
  input  logic [WAY_IW-1:0] touch_way,
  output logic [WAY_IW-1:0] victim_way
);

  localparam int DEPTH = 1 << SET_IW;
  localparam logic [WAY_IW-1:0] OLDEST = WAY_IW'(WAYS - 1);

  // rank 0 = newest, rank WAYS-1 = oldest; each set holds a permutation
  logic [WAY_IW-1:0] use_rk  [DEPTH][WAYS];
  logic [WAY_IW-1:0] fifo_rk [DEPTH][WAYS];
  logic [WAY_IW-1:0] use_old, fifo_old;
  logic [WAY_IW-1:0] lru_way, mru_way, fifo_way, rand_way;
  logic [15:0]       lfsr_q;

  always_comb begin
    use_old  = '0;
    fifo_old = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (touch_way == WAY_IW'(w)) begin
        use_old  = use_rk[set_idx][w];
        fifo_old = fifo_rk[set_idx][w];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < DEPTH; d++)
        for (int w = 0; w < WAYS; w++) begin
          use_rk[d][w]  <= WAY_IW'(w);
          fifo_rk[d][w] <= WAY_IW'(w);
        end
    end else if (clr) begin
      for (int d = 0; d < DEPTH; d++)
        for (int w = 0; w < WAYS; w++) begin
          use_rk[d][w]  <= WAY_IW'(w);
          fifo_rk[d][w] <= WAY_IW'(w);
        end
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (touch_way == WAY_IW'(w))
          use_rk[set_idx][w] <= '0;
        else if (use_rk[set_idx][w] < use_old)
          use_rk[set_idx][w] <= use_rk[set_idx][w] + 1'b1;
        if (touch_fill) begin
          if (touch_way == WAY_IW'(w))
            fifo_rk[set_idx][w] <= '0;
          else if (fifo_rk[set_idx][w] < fifo_old)
            fifo_rk[set_idx][w] <= fifo_rk[set_idx][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= LFSR_SEED;
    else        lfsr_q <= lfsr_q[0] ? ((lfsr_q >> 1) ^ LFSR_TAPS) : (lfsr_q >> 1);
  end

  generate
    if (WAYS == 1) begin : g_one_way
      assign rand_way = '0;
    end else begin : g_many_way
      assign rand_way = lfsr_q[WAY_IW-1:0];
    end
  endgenerate

  always_comb begin
    lru_way  = '0;
    mru_way  = '0;
    fifo_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (use_rk[set_idx][w] == OLDEST)  lru_way  = WAY_IW'(w);
      if (use_rk[set_idx][w] == '0)      mru_way  = WAY_IW'(w);
      if (fifo_rk[set_idx][w] == OLDEST) fifo_way = WAY_IW'(w);
    end
  end

  always_comb begin
    case (policy)
      POL_FIFO: victim_way = fifo_way;
      POL_LRU:  victim_way = lru_way;
      POL_MRU:  victim_way = mru_way;
      default:  victim_way = rand_way;
    endcase
  end

endmodule

// File: rtl/ctc_sat_counter.sv
module ctc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (inc && cnt != '1)   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int  ADDR_W    = 16,
  parameter int  WORD_BITS = 4,
  parameter int  LINES     = 128,
  parameter int  WAYS      = 4,
  parameter int  CNT_W     = 16,
  localparam int SETS      = LINES / WAYS,
  localparam int SET_BITS  = $clog2(SETS),
  localparam int SET_IW    = (SET_BITS > 0) ? SET_BITS : 1,
  localparam int WAY_IW    = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W     = ADDR_W - WORD_BITS - SET_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [1:0]        policy,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_evict,
  output logic [WAY_IW-1:0] rsp_way,
  output logic [SET_IW-1:0] rsp_set,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  repl_count
);

  logic [SET_IW-1:0] set_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic [WAYS-1:0]   hit_vec, valid_vec;
  logic [WAY_IW-1:0] hit_way, first_inv, victim_way, fill_way, touch_way;
  logic              hit, all_valid, accept, fill;
  repl_pol_e         pol;

  assign req_ready = !clr && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;
  assign pol       = repl_pol_e'(policy);

  ctc_addr_split #(
    .ADDR_W(ADDR_W), .WORD_BITS(WORD_BITS), .SET_BITS(SET_BITS),
    .SET_IW(SET_IW), .TAG_W(TAG_W)
  ) u_split (
    .addr(req_addr), .set_idx(set_idx), .tag(lk_tag)
  );

  ctc_way_array #(
    .WAYS(WAYS), .TAG_W(TAG_W), .SET_IW(SET_IW), .WAY_IW(WAY_IW)
  ) u_ways (
    .clk(clk), .rst_n(rst_n), .clr(clr), .set_idx(set_idx), .lk_tag(lk_tag),
    .wr_en(fill), .wr_way(fill_way), .hit_vec(hit_vec), .valid_vec(valid_vec)
  );

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_IW'(w);
  end

  always_comb begin
    first_inv = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_vec[w]) first_inv = WAY_IW'(w);
  end

  assign hit       = |hit_vec;
  assign all_valid = &valid_vec;
  assign fill      = accept && !hit;
  assign fill_way  = all_valid ? victim_way : first_inv;
  assign touch_way = hit ? hit_way : fill_way;

  ctc_repl_state #(
    .WAYS(WAYS), .WAY_IW(WAY_IW), .SET_IW(SET_IW)
  ) u_repl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .policy(pol), .set_idx(set_idx),
    .touch_en(accept), .touch_fill(fill), .touch_way(touch_way),
    .victim_way(victim_way)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_evict <= 1'b0;
      rsp_way   <= '0;
      rsp_set   <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= hit;
      rsp_evict <= !hit && all_valid;
      rsp_way   <= touch_way;
      rsp_set   <= set_idx;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  logic [2:0]       inc_vec;
  logic [CNT_W-1:0] cnt_arr [3];

  assign inc_vec = {fill && all_valid, fill, accept && hit};

  generate
    for (genvar g = 0; g < 3; g++) begin : g_cnt
      ctc_sat_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc_vec[g]), .cnt(cnt_arr[g])
      );
    end
  endgenerate

  assign hit_count  = cnt_arr[0];
  assign miss_count = cnt_arr[1];
  assign repl_count = cnt_arr[2];

endmodule

// File: rtl/ctc_checker.sv
module ctc_checker #(
  parameter int WAYS   = 4,
  parameter int CNT_W  = 16,
  parameter int WAY_IW = 2,
  parameter int SET_IW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic              rsp_evict,
  input logic [WAY_IW-1:0] rsp_way,
  input logic [SET_IW-1:0] rsp_set,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count,
  input logic [CNT_W-1:0]  repl_count
);

  p_accept_answers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_evict)
                                && $stable(rsp_way) && $stable(rsp_set));

  p_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  p_clr_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !req_ready);

  p_clr_zeroes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> hit_count == '0 && miss_count == '0 && repl_count == '0);

  p_evict_on_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_evict |-> !rsp_hit);

  p_way_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> int'(rsp_way) < WAYS);

  p_counts_monotonic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> hit_count >= $past(hit_count) && miss_count >= $past(miss_count)
             && repl_count >= $past(repl_count));

  p_repl_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    repl_count <= miss_count);

endmodule

bind cache_tag_ctrl ctc_checker #(
  .WAYS(WAYS), .CNT_W(CNT_W), .WAY_IW(WAY_IW), .SET_IW(SET_IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_evict(rsp_evict),
  .rsp_way(rsp_way), .rsp_set(rsp_set), .hit_count(hit_count), .miss_count(miss_count),
  .repl_count(repl_count)
);

// File: tb/test_cache_tag_ctrl.sv
module test_cache_tag_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // main instance: 16 lines, 4 ways, 4 sets, 4-word blocks
  logic        m_clr = 0, m_rv = 0, m_sr = 0;
  logic [1:0]  m_pol = 0;
  logic [11:0] m_addr = 0;
  logic        m_rr, m_sv, m_hit, m_ev;
  logic [1:0]  m_way, m_set;
  logic [5:0]  m_hc, m_mc, m_rc;

  cache_tag_ctrl #(.ADDR_W(12), .WORD_BITS(2), .LINES(16), .WAYS(4), .CNT_W(6)) i_cache_tag_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(m_clr), .policy(m_pol), .req_valid(m_rv), .req_ready(m_rr),
    .req_addr(m_addr), .rsp_valid(m_sv), .rsp_ready(m_sr), .rsp_hit(m_hit), .rsp_evict(m_ev),
    .rsp_way(m_way), .rsp_set(m_set), .hit_count(m_hc), .miss_count(m_mc), .repl_count(m_rc));

  // direct-mapped: 8 lines of 2 words
  logic        d_rv = 0;
  logic [10:0] d_addr = 0;
  logic        d_rr, d_sv, d_hit, d_ev;
  logic [0:0]  d_way;
  logic [2:0]  d_set;
  logic [7:0]  d_hc, d_mc, d_rc;

  cache_tag_ctrl #(.ADDR_W(11), .WORD_BITS(1), .LINES(8), .WAYS(1), .CNT_W(8)) i_dm (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .policy(2'd2), .req_valid(d_rv), .req_ready(d_rr),
    .req_addr(d_addr), .rsp_valid(d_sv), .rsp_ready(1'b1), .rsp_hit(d_hit), .rsp_evict(d_ev),
    .rsp_way(d_way), .rsp_set(d_set), .hit_count(d_hc), .miss_count(d_mc), .repl_count(d_rc));

  // fully associative: 4 lines, 4 ways
  logic        f_rv = 0;
  logic [1:0]  f_pol = 2;
  logic [7:0]  f_addr = 0;
  logic        f_rr, f_sv, f_hit, f_ev;
  logic [1:0]  f_way;
  logic [0:0]  f_set;
  logic [3:0]  f_hc, f_mc, f_rc;

  cache_tag_ctrl #(.ADDR_W(8), .WORD_BITS(1), .LINES(4), .WAYS(4), .CNT_W(4)) i_fa (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .policy(f_pol), .req_valid(f_rv), .req_ready(f_rr),
    .req_addr(f_addr), .rsp_valid(f_sv), .rsp_ready(1'b1), .rsp_hit(f_hit), .rsp_evict(f_ev),
    .rsp_way(f_way), .rsp_set(f_set), .hit_count(f_hc), .miss_count(f_mc), .repl_count(f_rc));

  task automatic chk_eq(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural model of the main instance
  bit mv[4][4];
  int mt[4][4];
  int fq[4][$];  // front = newest fill
  int rq[4][$];  // front = newest use
  int mh, mm, mr;

  task automatic model_reset();
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 4; w++) mv[s][w] = 0;
      fq[s].delete();
      rq[s].delete();
    end
    mh = 0; mm = 0; mr = 0;
  endtask

  task automatic touch_use(int s, int w);
    for (int i = 0; i < rq[s].size(); i++)
      if (rq[s][i] == w) begin rq[s].delete(i); break; end
    rq[s].push_front(w);
  endtask

  task automatic touch_fill(int s, int w);
    for (int i = 0; i < fq[s].size(); i++)
      if (fq[s][i] == w) begin fq[s].delete(i); break; end
    fq[s].push_front(w);
  endtask

  task automatic model_rsp(int a, int p);
    int s, t, ew;
    bit eh, ee, full;
    string vtag;
    s = (a >> 2) & 3;
    t = a >> 4;
    eh = 0; ee = 0; ew = 0; full = 1;
    vtag = "R3";
    for (int w = 0; w < 4; w++)
      if (mv[s][w] && mt[s][w] == t) begin eh = 1; ew = w; end
    if (eh) begin
      vtag = "R2";
      touch_use(s, ew);
      if (mh < 63) mh++;
    end else begin
      for (int w = 3; w >= 0; w--) if (!mv[s][w]) begin full = 0; ew = w; end
      if (full) begin
        ee = 1;
        case (p)
          0: begin ew = int'(m_way); vtag = "R4"; end
          1: begin ew = fq[s][fq[s].size()-1]; vtag = "R5"; end
          2: begin ew = rq[s][rq[s].size()-1]; vtag = "R6"; end
          default: begin ew = rq[s][0]; vtag = "R6"; end
        endcase
      end
      mv[s][ew] = 1;
      mt[s][ew] = t;
      touch_fill(s, ew);
      touch_use(s, ew);
      if (mm < 63) mm++;
      if (full && mr < 63) mr++;
    end
    chk_eq(eh ? "R2" : "R3", "rsp_hit", m_hit, eh);
    chk_eq(vtag, "rsp_way", m_way, ew);
    chk_eq("R4", "rsp_evict", m_ev, ee);
    chk_eq("R1", "rsp_set", m_set, s);
  endtask

  function automatic int gen_addr();
    int t;
    t = $urandom_range(0, 7);
    if (t >= 6) t += 240;
    return (t << 4) | ($urandom_range(0, 3) << 2) | $urandom_range(0, 3);
  endfunction

  task automatic dm_access(int a, inout int mask);
    @(negedge clk);
    d_rv = 1; d_addr = a[10:0];
    @(negedge clk);
    d_rv = 0;
    chk_eq("R11", "dm rsp_valid", d_sv, 1);
    chk_eq("R11", "dm miss", d_hit, 0);
    chk_eq("R7", "dm way", d_way, 0);
    mask = mask | (1 << d_set);
  endtask

  task automatic fa_access(int blk, int eh, int ew, int ee, string req);
    @(negedge clk);
    f_rv = 1; f_addr = 8'(blk * 2);
    @(negedge clk);
    f_rv = 0;
    chk_eq(req, "fa hit", f_hit, eh);
    chk_eq(req, "fa way", f_way, ew);
    chk_eq(req, "fa evict", f_ev, ee);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    bit fresh, pend_clr, outstanding;
    int pend_addr, pend_pol, mask;
    fresh = 0; pend_clr = 0; outstanding = 0; pend_addr = 0; pend_pol = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 / R8 reset state
    chk_eq("R10", "reset rsp_valid", m_sv, 0);
    chk_eq("R10", "reset hit_count", m_hc, 0);
    chk_eq("R10", "reset miss_count", m_mc, 0);
    chk_eq("R10", "reset repl_count", m_rc, 0);
    chk_eq("R8", "reset req_ready", m_rr, 1);

    for (int ph = 0; ph < 4; ph++) begin
      for (int c = 0; c < 260; c++) begin
        @(negedge clk);
        if (pend_clr) model_reset();
        if (fresh) model_rsp(pend_addr, pend_pol);
        chk_eq("R8", "rsp_valid", m_sv, outstanding);
        chk_eq("R9", "hit_count", m_hc, mh);
        chk_eq("R9", "miss_count", m_mc, mm);
        chk_eq("R9", "repl_count", m_rc, mr);
        m_pol = 2'(ph);
        m_clr = (c == 0) || (c > 40 && $urandom_range(0, 199) == 0);
        m_rv = ($urandom_range(0, 3) != 0) || (c == 259 ? 1'b0 : 1'b0);
        if (c == 259) m_rv = 0;
        m_addr = 12'(gen_addr());
        m_sr = ($urandom_range(0, 3) != 0);
        #1;
        chk_eq("R8", "req_ready", m_rr, int'(!m_clr && (!m_sv || m_sr)));
        fresh = m_rv && m_rr;
        pend_addr = m_addr;
        pend_pol = ph;
        pend_clr = m_clr;
        if (fresh) outstanding = 1;
        else if (m_sv && m_sr) outstanding = 0;
      end
    end
    @(negedge clk);
    if (fresh) model_rsp(pend_addr, pend_pol);
    m_sr = 1;

    // R11 column-major array case on the direct-mapped instance
    mask = 0;
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 8; j++)
        dm_access(1000 + 4 * j + i, mask);
    chk_eq("R11", "dm hits", d_hc, 0);
    chk_eq("R11", "dm misses", d_mc, 16);
    chk_eq("R11", "dm replacements", d_rc, 12);
    chk_eq("R11", "dm lines used", $countones(mask), 4);

    // R7 fully associative placement with policy-specific victims
    f_pol = 2;
    fa_access(0, 0, 0, 0, "R7");
    fa_access(1, 0, 1, 0, "R7");
    fa_access(2, 0, 2, 0, "R3");
    fa_access(3, 0, 3, 0, "R3");
    fa_access(0, 1, 0, 0, "R2");
    fa_access(9, 0, 1, 1, "R6");   // LRU
    f_pol = 3;
    fa_access(10, 0, 1, 1, "R6");  // MRU
    f_pol = 1;
    fa_access(11, 0, 0, 1, "R5");  // FIFO ignores the hit on block 0
    fa_access(3, 1, 3, 0, "R2");
    chk_eq("R9", "fa hits", f_hc, 2);
    chk_eq("R9", "fa misses", f_mc, 7);
    chk_eq("R9", "fa replacements", f_rc, 3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule